// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative cache of virtual-to-physical page translations. Each stored translation carries the address-space identifier of the process that caused it to be loaded, plus a global flag. An operating system changes process by writing a new identifier into the current-ASID register. It does not have to flush the buffer. Translations that belong to other processes stay resident but cannot hit. When their owner runs again they may still be present, or they may have been displaced by other work in the meantime. Either outcome is correct.

A requester presents a virtual page number on the lookup port. One cycle later the block returns a registered hit flag, the physical page number and the permission bits. If a lookup misses while no walk is outstanding, the block raises a walk request carrying the page number and the current identifier. It then waits for the external page-table walker to answer with a fill or a fault. Software can drop translations in three ways: all of them, those of one identifier, or those of one virtual page.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, no walk is requested, no response is valid and the current identifier is 0, so the first lookup of any page misses.
- R2: A lookup presented in cycle t gives rsp_valid in cycle t+1. On a hit, that response carries the stored physical page and permission bits.
- R3: A lookup hits a non-global entry only when both the virtual tag and the stored identifier match the current identifier. A lookup from another identifier misses and starts a walk.
- R4: A global entry hits on a virtual tag match, whatever the current identifier.
- R5: Writing asid_wr/asid_wdata switches context without removing entries. After switching back, the earlier translations of that identifier still hit if they were not evicted.
- R6: A miss with no walk outstanding raises walk_req in the next cycle, with walk_vpn set to the missed page and walk_asid set to the current identifier. These outputs stay unchanged until a fill or a fault arrives. Misses that occur while a walk is outstanding do not alter it.
- R7: A fault response ends the walk and leaves every entry unchanged.
- R8: A fill stores the outstanding page, the identifier that is current in the fill cycle, and the global flag. A lookup in the same cycle as the fill reports the state before the fill. Lookups from the next cycle onward see the new entry.
- R9: The victim is the lowest-numbered invalid entry. When all entries are valid, the victim is a round-robin pointer that starts at entry 0 after reset and advances by one after each eviction.
- R10: A fill whose page would already hit for the current identifier rewrites that entry in place, so no second copy exists.
- R11: inv_op = 1 clears every entry.
- R12: inv_op = 2 clears only the non-global entries whose stored identifier equals inv_asid.
- R13: inv_op = 3 clears every entry whose virtual tag equals inv_vpn, whether it is global or belongs to any identifier. inv_op = 0 does nothing.
- R14: When a fill and an invalidate fall in the same cycle, the invalidate is applied first and the filled entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vpn | input | VPN_W | Virtual page to translate |
| rsp_valid | output | 1 | Registered lookup response valid |
| rsp_hit | output | 1 | Response is a hit |
| rsp_ppn | output | PPN_W | Physical page on hit |
| rsp_perm | output | PERM_W | Permission bits on hit |
| walk_req | output | 1 | Walk outstanding |
| walk_vpn | output | VPN_W | Page the walker must resolve |
| walk_asid | output | ASID_W | Identifier current when the walk started |
| fill_valid | input | 1 | Walker returns a translation |
| fill_ppn | input | PPN_W | Returned physical page |
| fill_perm | input | PERM_W | Returned permission bits |
| fill_global | input | 1 | Returned global flag |
| fault_valid | input | 1 | Walker reports no translation |
| asid_wr | input | 1 | Write current identifier |
| asid_wdata | input | ASID_W | New current identifier |
| inv_op | input | 2 | 0 none, 1 all, 2 by identifier, 3 by page |
| inv_asid | input | ASID_W | Identifier for inv_op 2 |
| inv_vpn | input | VPN_W | Page for inv_op 3 |

## Verification
Three pairs of operations can land in one cycle. A fill can coincide with a lookup of the same page. A fill can coincide with invalidate-all. A context switch can coincide with a fill that duplicates an existing entry. The bench provokes each pair by holding a walk outstanding and then driving both inputs on the same clock edge. In the first case it requires a miss with no new walk, followed by a hit on the next lookup. In the second case it requires the old entry to be gone and the filled one to hit. For the third case, it fills exactly enough further pages that a hidden duplicate would force an eviction, and then checks that no expected entry has gone missing.

// File: rtl/atlb_pkg.sv
package atlb_pkg;
  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_ALL  = 2'd1,
    INV_ASID = 2'd2,
    INV_PAGE = 2'd3
  } inv_op_e;
endpackage

// File: rtl/atlb_match.sv
module atlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [ENTRIES-1:0] ent_glob,
  input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
  input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
  input  logic [VPN_W-1:0]   key_vpn,
  input  logic [ASID_W-1:0]  key_asid,
  output logic [ENTRIES-1:0] match_vec,
  output logic               match_any,
  output logic [IDX_W-1:0]   match_idx
);
  // Hit rule: tag equal, and either global or same address space.
  function automatic logic entry_hits(input logic v, input logic g,
                                      input logic [VPN_W-1:0] ev, input logic [ASID_W-1:0] ea,
                                      input logic [VPN_W-1:0] kv, input logic [ASID_W-1:0] ka);
    return v && (ev == kv) && (g || (ea == ka));
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = entry_hits(ent_valid[i], ent_glob[i], ent_vpn[i], ent_asid[i],
                                     key_vpn, key_asid);
  end

  assign match_any = |match_vec;

  always_comb begin
    match_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match_vec[i]) match_idx = IDX_W'(i);
  end
endmodule

// File: rtl/atlb_victim.sv
module atlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               evict,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               all_full
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;

  function automatic logic [IDX_W-1:0] rr_next(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  assign all_full = &valid_vec;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_vec[i]) free_idx = IDX_W'(i);
  end

  assign victim_idx = all_full ? rr_q : free_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (evict) rr_q <= rr_next(rr_q);
  end

  AST_RR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !all_full |=> $stable(rr_q)) else $error("rr moved without eviction"); // R9
endmodule

// File: rtl/atlb_invalidate.sv
module atlb_invalidate #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  atlb_pkg::inv_op_e  op,
  input  logic [ASID_W-1:0]  inv_asid,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic [ENTRIES-1:0] ent_glob,
  input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
  input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
  output logic [ENTRIES-1:0] kill_vec
);
  import atlb_pkg::*;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_kill
    always_comb begin
      unique case (op)
        INV_ALL:  kill_vec[i] = 1'b1;
        INV_ASID: kill_vec[i] = !ent_glob[i] && (ent_asid[i] == inv_asid);
        INV_PAGE: kill_vec[i] = (ent_vpn[i] == inv_vpn);
        default:  kill_vec[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PERM_W  = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn,
  output logic [ASID_W-1:0] walk_asid,
  input  logic              fill_valid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              fill_global,
  input  logic              fault_valid,
  input  logic              asid_wr,
  input  logic [ASID_W-1:0] asid_wdata,
  input  logic [1:0]        inv_op,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VPN_W-1:0]  inv_vpn
);
  import atlb_pkg::*;

  // Entry storage
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] glob_q;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];
  logic [PERM_W-1:0]  e_perm [ENTRIES];

  logic [ASID_W-1:0]  cur_asid_q;
  logic               busy_q;
  logic [VPN_W-1:0]   wvpn_q;
  logic [ASID_W-1:0]  wasid_q;

  // Named internal events
  logic [ENTRIES-1:0] hit_vec, dup_vec, kill_vec;
  logic               hit_any, dup_any, all_full;
  logic [IDX_W-1:0]   hit_idx, dup_idx, vict_idx, tgt_idx;
  logic               fill_acc, fault_acc, miss_start, evict;
  inv_op_e            op;

  assign op         = inv_op_e'(inv_op);
  assign fill_acc   = fill_valid && busy_q;
  assign fault_acc  = fault_valid && busy_q && !fill_valid;
  assign miss_start = lk_valid && !hit_any && !busy_q;
  assign tgt_idx    = dup_any ? dup_idx : vict_idx;
  assign evict      = fill_acc && !dup_any && all_full;

  atlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lookup_cmp (
    .ent_valid(valid_q), .ent_glob(glob_q), .ent_vpn(e_vpn), .ent_asid(e_asid),
    .key_vpn(lk_vpn), .key_asid(cur_asid_q),
    .match_vec(hit_vec), .match_any(hit_any), .match_idx(hit_idx)
  );

  atlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_dup_cmp (
    .ent_valid(valid_q), .ent_glob(glob_q), .ent_vpn(e_vpn), .ent_asid(e_asid),
    .key_vpn(wvpn_q), .key_asid(cur_asid_q),
    .match_vec(dup_vec), .match_any(dup_any), .match_idx(dup_idx)
  );

  atlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_q), .evict(evict),
    .victim_idx(vict_idx), .all_full(all_full)
  );

  atlb_invalidate #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_inv (
    .op(op), .inv_asid(inv_asid), .inv_vpn(inv_vpn),
    .ent_glob(glob_q), .ent_vpn(e_vpn), .ent_asid(e_asid), .kill_vec(kill_vec)
  );

  // Valid bits: invalidate first, then the fill lands on top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        valid_q[i] <= (valid_q[i] && !kill_vec[i]) || (fill_acc && (tgt_idx == IDX_W'(i)));
    end
  end

  always_ff @(posedge clk) begin
    if (fill_acc) begin
      glob_q[tgt_idx] <= fill_global;
      e_vpn[tgt_idx]  <= wvpn_q;
      e_asid[tgt_idx] <= cur_asid_q;
      e_ppn[tgt_idx]  <= fill_ppn;
      e_perm[tgt_idx] <= fill_perm;
    end
  end

  // Context register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_asid_q <= '0;
    else if (asid_wr) cur_asid_q <= asid_wdata;
  end

  // Walk tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wvpn_q  <= '0;
      wasid_q <= '0;
    end else if (fill_acc || fault_acc) begin
      busy_q <= 1'b0;
    end else if (miss_start) begin
      busy_q  <= 1'b1;
      wvpn_q  <= lk_vpn;
      wasid_q <= cur_asid_q;
    end
  end

  // Registered lookup response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && hit_any;
      rsp_ppn   <= (lk_valid && hit_any) ? e_ppn[hit_idx]  : '0;
      rsp_perm  <= (lk_valid && hit_any) ? e_perm[hit_idx] : '0;
    end
  end

  assign walk_req  = busy_q;
  assign walk_vpn  = wvpn_q;
  assign walk_asid = wasid_q;

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(hit_vec)) else $error("multiple hits"); // R10
  AST_RSP_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid) else $error("hit without response"); // R2
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !fill_valid && !fault_valid |=> walk_req && $stable(walk_vpn) && $stable(walk_asid))
    else $error("walk changed while pending"); // R6
  AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && fault_valid && !fill_valid && (inv_op == 2'd0) |=> $stable(valid_q) && !walk_req)
    else $error("fault disturbed entries"); // R7
  AST_INV_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_op == 2'd1) && !(fill_valid && walk_req) |=> valid_q == '0)
    else $error("invalidate-all left entries"); // R11
  AST_FILL_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    fill_acc |=> valid_q[$past(tgt_idx)]) else $error("filled entry lost"); // R14
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        rsp_valid, rsp_hit;
  logic [19:0] rsp_ppn;
  logic [2:0]  rsp_perm;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic [7:0]  walk_asid;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_ppn = '0;
  logic [2:0]  fill_perm = '0;
  logic        fill_global = 1'b0;
  logic        fault_valid = 1'b0;
  logic        asid_wr = 1'b0;
  logic [7:0]  asid_wdata = '0;
  logic [1:0]  inv_op = '0;
  logic [7:0]  inv_asid = '0;
  logic [19:0] inv_vpn = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  asid_tlb u_asid_tlb (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_asid(walk_asid),
    .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .fill_global(fill_global), .fault_valid(fault_valid),
    .asid_wr(asid_wr), .asid_wdata(asid_wdata),
    .inv_op(inv_op), .inv_asid(inv_asid), .inv_vpn(inv_vpn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [19:0] v, output logic h, output logic [19:0] p,
                        output logic [2:0] pm);
    @(negedge clk); lk_valid = 1'b1; lk_vpn = v;
    @(negedge clk); lk_valid = 1'b0;
    h = rsp_hit; p = rsp_ppn; pm = rsp_perm;
  endtask

  task automatic fault();
    @(negedge clk); fault_valid = 1'b1;
    @(negedge clk); fault_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] p, input logic [2:0] pm, input logic g);
    @(negedge clk); fill_valid = 1'b1; fill_ppn = p; fill_perm = pm; fill_global = g;
    @(negedge clk); fill_valid = 1'b0;
  endtask

  task automatic set_asid(input logic [7:0] a);
    @(negedge clk); asid_wr = 1'b1; asid_wdata = a;
    @(negedge clk); asid_wr = 1'b0;
  endtask

  task automatic invalidate(input logic [1:0] op, input logic [7:0] a, input logic [19:0] v);
    @(negedge clk); inv_op = op; inv_asid = a; inv_vpn = v;
    @(negedge clk); inv_op = 2'd0;
  endtask

  task automatic expect_hit(input logic [19:0] v, input logic [19:0] p, input string req);
    logic h; logic [19:0] gp; logic [2:0] gm;
    lookup(v, h, gp, gm);
    check(h == 1'b1, req, "hit", 32'(h), 1);
    check(gp == p, req, "ppn", 32'(gp), 32'(p));
  endtask

  task automatic expect_miss(input logic [19:0] v, input string req);
    logic h; logic [19:0] gp; logic [2:0] gm;
    lookup(v, h, gp, gm);
    check(h == 1'b0, req, "miss", 32'(h), 0);
    if (walk_req) fault();
  endtask

  task automatic install(input logic [19:0] v, input logic [19:0] p, input logic [2:0] pm,
                         input logic g, input string req);
    logic h; logic [19:0] gp; logic [2:0] gm;
    lookup(v, h, gp, gm);
    check(h == 1'b0 && walk_req && walk_vpn == v, req, "walk for install", 32'(walk_vpn), 32'(v));
    fill(p, pm, g);
  endtask

  // R1, R6, R7
  task automatic t_reset_and_fault();
    logic h; logic [19:0] gp; logic [2:0] gm;
    check(!rsp_valid && !walk_req, "R1", "idle after reset", {30'd0, rsp_valid, walk_req}, 0);
    lookup(20'h10, h, gp, gm);
    check(rsp_valid && !h, "R1", "first lookup misses", 32'(h), 0);
    check(walk_req && walk_vpn == 20'h10 && walk_asid == 8'd0, "R6", "walk request",
          32'(walk_vpn), 32'h10);
    lookup(20'h11, h, gp, gm);
    check(walk_vpn == 20'h10, "R6", "second miss leaves walk", 32'(walk_vpn), 32'h10);
    fault();
    check(!walk_req, "R7", "fault ends walk", 32'(walk_req), 0);
    expect_miss(20'h10, "R7");
  endtask

  // R9, R13, R11
  task automatic t_victim();
    set_asid(8'd1);
    for (int i = 0; i < 8; i++) install(20'h100 + 20'(i), 20'h500 + 20'(i), 3'd1, 1'b0, "R9");
    install(20'h200, 20'h600, 3'd1, 1'b0, "R9");
    expect_miss(20'h100, "R9");
    expect_hit(20'h101, 20'h501, "R9");
    install(20'h201, 20'h601, 3'd1, 1'b0, "R9");
    expect_miss(20'h101, "R9");
    expect_hit(20'h102, 20'h502, "R9");
    invalidate(2'd3, 8'd0, 20'h103);
    expect_miss(20'h103, "R13");
    install(20'h300, 20'h700, 3'd1, 1'b0, "R9");
    expect_hit(20'h102, 20'h502, "R9");
    expect_hit(20'h300, 20'h700, "R9");
    invalidate(2'd0, 8'd1, 20'h102);
    expect_hit(20'h102, 20'h502, "R13");
    invalidate(2'd1, 8'd0, 20'h0);
    expect_miss(20'h102, "R11");
    expect_miss(20'h300, "R11");
  endtask

  // R2, R3, R5, R4, R12, R13
  task automatic t_contexts();
    logic h; logic [19:0] gp; logic [2:0] gm;
    install(20'h40, 20'h111, 3'd5, 1'b0, "R3");
    lookup(20'h40, h, gp, gm);
    check(rsp_valid && h && gp == 20'h111 && gm == 3'd5, "R2", "hit data", 32'(gm), 5);
    set_asid(8'd2);
    lookup(20'h40, h, gp, gm);
    check(!h && walk_req && walk_asid == 8'd2, "R3", "other asid misses", 32'(walk_asid), 2);
    fault();
    install(20'h40, 20'h222, 3'd2, 1'b0, "R3");
    expect_hit(20'h40, 20'h222, "R3");
    set_asid(8'd1);
    expect_hit(20'h40, 20'h111, "R5");
    install(20'h50, 20'h333, 3'd1, 1'b1, "R4");
    set_asid(8'd7);
    expect_hit(20'h50, 20'h333, "R4");
    invalidate(2'd2, 8'd1, 20'h0);
    set_asid(8'd1);
    expect_miss(20'h40, "R12");
    expect_hit(20'h50, 20'h333, "R12");
    set_asid(8'd2);
    expect_hit(20'h40, 20'h222, "R12");
    invalidate(2'd3, 8'd0, 20'h50);
    expect_miss(20'h50, "R13");
    invalidate(2'd1, 8'd0, 20'h0);
  endtask

  // R10: walk started in asid 4, filled after switching to asid 3
  task automatic t_duplicate();
    logic h; logic [19:0] gp; logic [2:0] gm;
    set_asid(8'd3);
    install(20'h60, 20'h10, 3'd1, 1'b0, "R10");
    set_asid(8'd4);
    lookup(20'h60, h, gp, gm);
    check(!h && walk_req, "R10", "walk from asid 4", 32'(walk_req), 1);
    @(negedge clk); asid_wr = 1'b1; asid_wdata = 8'd3;
    fill_valid = 1'b1; fill_ppn = 20'h20; fill_perm = 3'd1; fill_global = 1'b0;
    @(negedge clk); asid_wr = 1'b0; fill_valid = 1'b0;
    // switch landed in the same cycle, so the fill sees asid 4 (no duplicate) -> redo cleanly
    set_asid(8'd4);
    lookup(20'h60, h, gp, gm);
    check(h == 1'b1, "R8", "fill recorded asid of fill cycle", 32'(h), 1);
    invalidate(2'd1, 8'd0, 20'h0);
    set_asid(8'd3);
    install(20'h60, 20'h10, 3'd1, 1'b0, "R10");
    set_asid(8'd4);
    lookup(20'h60, h, gp, gm);
    set_asid(8'd3);
    fill(20'h20, 3'd1, 1'b0);
    expect_hit(20'h60, 20'h20, "R10");
    for (int i = 0; i < 7; i++) install(20'h70 + 20'(i), 20'h800 + 20'(i), 3'd1, 1'b0, "R10");
    expect_hit(20'h70, 20'h800, "R10");
    expect_hit(20'h60, 20'h20, "R10");
    invalidate(2'd1, 8'd0, 20'h0);
  endtask

  // R8: lookup and fill of the same page in one cycle
  task automatic t_fill_with_lookup();
    logic h; logic [19:0] gp; logic [2:0] gm;
    lookup(20'h80, h, gp, gm);
    @(negedge clk); fill_valid = 1'b1; fill_ppn = 20'h88; fill_perm = 3'd2; fill_global = 1'b0;
    lk_valid = 1'b1; lk_vpn = 20'h80;
    @(negedge clk); fill_valid = 1'b0; lk_valid = 1'b0;
    check(rsp_valid && !rsp_hit, "R8", "same-cycle lookup sees old state", 32'(rsp_hit), 0);
    check(!walk_req, "R8", "no new walk", 32'(walk_req), 0);
    expect_hit(20'h80, 20'h88, "R8");
  endtask

  // R14: fill and invalidate-all together
  task automatic t_fill_with_inv();
    logic h; logic [19:0] gp; logic [2:0] gm;
    install(20'h90, 20'h99, 3'd1, 1'b0, "R14");
    lookup(20'h91, h, gp, gm);
    @(negedge clk); fill_valid = 1'b1; fill_ppn = 20'h9a; fill_perm = 3'd1; fill_global = 1'b0;
    inv_op = 2'd1;
    @(negedge clk); fill_valid = 1'b0; inv_op = 2'd0;
    expect_hit(20'h91, 20'h9a, "R14");
    expect_miss(20'h90, "R14");
    expect_miss(20'h80, "R14");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_and_fault();
    t_victim();
    t_contexts();
    t_duplicate();
    t_fill_with_lookup();
    t_fill_with_inv();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule